// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block is a single-channel pulse-width modulator behind a small memory-mapped register bank. Software sets a period and a prescale ratio, then streams duty values into a four-word queue. At the start of every output period the engine may take the next queued value. Each queued value can be held for 1, 2, 4 or 8 periods before the next one is taken. If the queue is empty when a period ends, the last value keeps running.

The output can be driven normally, inverted or held low. It is always low while the channel is disabled. A self-clearing soft reset returns every register to its reset value and empties the queue. Sticky status flags report counter rollover, compare match and a write into a full queue. Each of these flags is cleared by writing 1 to it.

There are two state machines. The bus-side controller has two states. `ST_READY` accepts register writes. `ST_SWRST` holds the block in reset for `RST_CYCLES` clocks. It enters `ST_SWRST` on a control write with the reset bit set and returns to `ST_READY` when its down-counter reaches zero. The period engine has two states. `ENG_IDLE` holds the counter at zero. `ENG_RUN` advances it on every prescaler tick. The engine goes from idle to run when the enable bit is set, and from run to idle when the enable bit is cleared or a soft reset is in progress.

Top module: `pwm_fifo_gen`

## Requirements
- R1: Register offsets are: control 0x00, status 0x04, sample 0x0C, period 0x10. After reset, control reads 0x0, status reads 0x08 and period reads 0xFFFE.
- R2: An output period lasts (period register + 2) prescaler ticks, and a period value of 0xFFFF acts as 0xFFFE. With a divide ratio of 1, the rollover flag first reads 1 exactly period+3 clocks after the write edge that sets the enable bit.
- R3: Control bits 15:4 hold the divide ratio minus one, so each counter step takes between 1 and 4096 clocks.
- R4: Control bits 19:18 select the output mode. 0 drives high while the counter is below the active duty. 1 drives the complement of mode 0. 2 and 3 hold the output low.
- R5: While control bit 0 (enable) is 0, the output is low in every mode.
- R6: Writing 1 to control bit 3 starts a soft reset. Bit 3 reads 1 for `RST_CYCLES` clocks and then 0. All registers take their reset values and the queue is emptied.
- R7: A write to the sample register appends its low 16 bits to the queue. Status bits 2:0 give the number of queued words (0 to 4), and status bit 3 reads 1 whenever the queue is empty.
- R8: A sample write while the queue holds 4 words is discarded and sets status bit 6.
- R9: Control bits 2:1 = c make each queued value last 2^c periods. The first value is taken when the engine starts, and the next one is taken at the end of its 2^c-th period.
- R10: When a period ends and the queue is empty, the active duty value is kept.
- R11: Status bit 4 is set at every counter rollover and status bit 5 whenever the counter equals the active duty. Bits 4 to 6 stay set until a 1 is written to them.
- R12: Reading the sample register returns the active duty while enabled, and 0 while disabled.
- R13: Control bits 17:16 = 0 stop the prescaler and counter. Any nonzero value lets them run from the block clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
On every cycle, the assertions check the following. The output is low while disabled. The queue never reports more than four words, and a write to a full queue leaves the count unchanged. A soft reset leaves the queue empty and returns to the ready state on time. The counter restarts at zero after each rollover, and the duty value changes only at a period boundary.

Only the bench scenarios can show the quantities that depend on timing. These are the high-time ratio over whole periods for each period, duty, divide ratio and polarity. They also include the exact clock count to the first rollover, including for the 0xFFFF case, and the period in which the repeat setting releases the next queued value.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_STATUS = 'h04;
    localparam int OFF_SAMPLE = 'h0C;
    localparam int OFF_PERIOD = 'h10;

    typedef enum logic [1:0] {
        OUT_NORMAL  = 2'd0,
        OUT_INVERT  = 2'd1,
        OUT_OFF     = 2'd2,
        OUT_OFF_ALT = 2'd3
    } out_mode_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_SWRST = 1'b1
    } ctl_state_e;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;
endpackage

// File: rtl/pwm_duty_fifo.sv
module pwm_duty_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  rd_q, wr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              do_push, do_pop;

    assign do_pop  = pop_i && (cnt_q != '0);
    assign do_push = push_i && ((cnt_q != CNT_W'(DEPTH)) || do_pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (flush_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush_i) mem_q[wr_q] <= data_i;
    end

    assign head_o  = mem_q[rd_q];
    assign count_o = cnt_q;

    AST_FIFO_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R7
    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !flush_i && cnt_q == CNT_W'(DEPTH)) |=> (cnt_q == CNT_W'(DEPTH))); // R8
endmodule

// File: rtl/pwm_period_engine.sv
module pwm_period_engine
    import pwm_fifo_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic             gate_i,
    input  logic [PRE_W-1:0] div_m1_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [1:0]       rep_i,
    input  out_mode_e        mode_i,
    input  logic [CNT_W-1:0] head_i,
    input  logic             head_valid_i,
    output logic             pop_o,
    output logic             wrap_o,
    output logic             match_o,
    output logic [CNT_W-1:0] duty_o,
    output logic             pwm_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    eng_state_e       st_q, st_d;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q, duty_q, eff_period, limit;
    logic [2:0]       rep_q;
    logic [3:0]       rep_span;
    logic             tick, start, rep_last, active;

    assign eff_period = (period_i == CNT_MAX) ? CNT_MAX - 1'b1 : period_i;
    assign limit      = eff_period + 1'b1;
    assign tick       = (st_q == ENG_RUN) && enable_i && gate_i && (pre_q >= div_m1_i);
    assign wrap_o     = tick && (cnt_q >= limit);
    assign start      = (st_q == ENG_IDLE) && enable_i && !clear_i;
    assign rep_span   = 4'd1 << rep_i;
    assign rep_last   = ({1'b0, rep_q} == rep_span - 4'd1);
    assign pop_o      = head_valid_i && !clear_i && (start || (wrap_o && rep_last));
    assign match_o    = (st_q == ENG_RUN) && enable_i && (cnt_q == duty_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENG_IDLE: if (enable_i && !clear_i) st_d = ENG_RUN;
            ENG_RUN:  if (!enable_i || clear_i) st_d = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ENG_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0; cnt_q <= '0; duty_q <= '0; rep_q <= '0;
        end else if (clear_i) begin
            pre_q <= '0; cnt_q <= '0; duty_q <= '0; rep_q <= '0;
        end else begin
            unique case (st_q)
                ENG_IDLE: begin
                    pre_q <= '0;
                    cnt_q <= '0;
                    if (start) begin
                        rep_q <= '0;
                        if (head_valid_i) duty_q <= head_i;
                    end
                end
                ENG_RUN: begin
                    if (!enable_i) begin
                        pre_q <= '0;
                        cnt_q <= '0;
                    end else if (gate_i) begin
                        if (tick) begin
                            pre_q <= '0;
                            if (wrap_o) begin
                                cnt_q <= '0;
                                rep_q <= rep_last ? 3'd0 : rep_q + 3'd1;
                                if (rep_last && head_valid_i) duty_q <= head_i;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end else begin
                            pre_q <= pre_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        active = (cnt_q < duty_q);
        pwm_o  = 1'b0;
        if ((st_q == ENG_RUN) && enable_i) begin
            unique case (mode_i)
                OUT_NORMAL:  pwm_o = active;
                OUT_INVERT:  pwm_o = !active;
                OUT_OFF:     pwm_o = 1'b0;
                OUT_OFF_ALT: pwm_o = 1'b0;
            endcase
        end
    end

    assign duty_o = duty_q;

    AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0)); // R2
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ENG_RUN) && !wrap_o && !clear_i) |=> $stable(duty_q)); // R10
endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwm_fifo_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int CNT_W      = 16,
    parameter int PRE_W      = 12,
    parameter int FIFO_DEPTH = 4,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              pwm_out
);
    localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int RST_W  = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] PERIOD_RST = {{(CNT_W-1){1'b1}}, 1'b0};

    ctl_state_e         st_q, st_d;
    logic [RST_W-1:0]   rcnt_q;
    logic               en_q;
    logic [1:0]         rep_q, gate_q;
    logic [PRE_W-1:0]   presc_q;
    out_mode_e          mode_q;
    logic [CNT_W-1:0]   period_q, duty;
    logic               rov_q, cmp_q, werr_q;
    logic [FCNT_W-1:0]  fcnt;
    logic [CNT_W-1:0]   head;
    logic               ready, wr_ctrl, wr_stat, wr_samp, wr_per, swr_req, clear;
    logic               pop, wrap, match, fifo_full;

    assign ready     = (st_q == ST_READY);
    assign wr_ctrl   = ready && wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign wr_stat   = ready && wr_en && (addr == ADDR_W'(OFF_STATUS));
    assign wr_samp   = ready && wr_en && (addr == ADDR_W'(OFF_SAMPLE));
    assign wr_per    = ready && wr_en && (addr == ADDR_W'(OFF_PERIOD));
    assign swr_req   = wr_ctrl && wdata[3];
    assign clear     = swr_req || (st_q == ST_SWRST);
    assign fifo_full = (fcnt == FCNT_W'(FIFO_DEPTH));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READY: if (swr_req) st_d = ST_SWRST;
            ST_SWRST: if (rcnt_q == '0) st_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_READY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rcnt_q <= '0;
        else if (swr_req)        rcnt_q <= RST_W'(RST_CYCLES - 1);
        else if (rcnt_q != '0)   rcnt_q <= rcnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; rep_q <= '0; gate_q <= '0; presc_q <= '0; mode_q <= OUT_NORMAL;
            period_q <= PERIOD_RST; rov_q <= 1'b0; cmp_q <= 1'b0; werr_q <= 1'b0;
        end else if (clear) begin
            en_q <= 1'b0; rep_q <= '0; gate_q <= '0; presc_q <= '0; mode_q <= OUT_NORMAL;
            period_q <= PERIOD_RST; rov_q <= 1'b0; cmp_q <= 1'b0; werr_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q    <= wdata[0];
                rep_q   <= wdata[2:1];
                presc_q <= wdata[15:4];
                gate_q  <= wdata[17:16];
                mode_q  <= out_mode_e'(wdata[19:18]);
            end
            if (wr_per) period_q <= wdata[CNT_W-1:0];
            rov_q  <= (rov_q  && !(wr_stat && wdata[4])) || wrap;
            cmp_q  <= (cmp_q  && !(wr_stat && wdata[5])) || match;
            werr_q <= (werr_q && !(wr_stat && wdata[6])) || (wr_samp && fifo_full);
        end
    end

    pwm_duty_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush_i(clear), .push_i(wr_samp),
        .data_i(wdata[CNT_W-1:0]), .pop_i(pop), .head_o(head), .count_o(fcnt)
    );

    pwm_period_engine #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .enable_i(en_q),
        .gate_i(gate_q != 2'd0), .div_m1_i(presc_q), .period_i(period_q),
        .rep_i(rep_q), .mode_i(mode_q), .head_i(head), .head_valid_i(fcnt != '0),
        .pop_o(pop), .wrap_o(wrap), .match_o(match), .duty_o(duty), .pwm_o(pwm_out)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(OFF_CTRL):   rdata = {12'd0, mode_q, gate_q, presc_q, (st_q == ST_SWRST), rep_q, en_q};
            ADDR_W'(OFF_STATUS): rdata = {25'd0, werr_q, cmp_q, rov_q, (fcnt == '0), 3'(fcnt)};
            ADDR_W'(OFF_SAMPLE): rdata = en_q ? 32'(duty) : 32'd0;
            ADDR_W'(OFF_PERIOD): rdata = 32'(period_q);
            default:             rdata = '0;
        endcase
    end

    wire unused_wdata = &{1'b0, wdata[31:20], 1'b0};

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pwm_out); // R5
    AST_SWR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SWRST) |=> (fcnt == '0)); // R6
    AST_SWR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SWRST) && (rcnt_q == '0)) |=> (st_q == ST_READY)); // R6
endmodule

// File: tb/pwm_fifo_gen_tb.sv
module pwm_fifo_gen_tb;
    localparam int RSTC = 4;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    pwm_fifo_gen #(.RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic soft_reset();
        logic [31:0] v;
        int guard;
        wr(5'h00, 32'h8);
        guard = 0;
        rd(5'h00, v);
        while (v[3] && guard < 50) begin
            @(negedge clk);
            guard++;
            rd(5'h00, v);
        end
    endtask

    task automatic count_high(input int len, output int highs);
        highs = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
    endtask

    task automatic sweep_point(input int p, input int d, input int dv, input int mode, input bit en);
        int len, highs, hi_exp;
        soft_reset();
        wr(5'h10, 32'(p));
        wr(5'h0C, 32'(d));
        wr(5'h00, (32'(mode) << 18) | (32'd1 << 16) | (32'(dv - 1) << 4) | 32'(en));
        len = (p + 2) * dv;
        repeat (3 * len + 4) @(negedge clk);
        count_high(len, highs);
        hi_exp = ((d < p + 2) ? d : p + 2) * dv;
        if (!en || mode >= 2) hi_exp = 0;
        else if (mode == 1)   hi_exp = len - hi_exp;
        check("R4/R3/R10 high time per period", highs, hi_exp);
    endtask

    task automatic first_rollover(input int p, input int bound, output int n);
        logic [31:0] v;
        soft_reset();
        wr(5'h10, 32'(p));
        wr(5'h00, 32'h1_0001);
        n = 0;
        v = '0;
        while (!v[4] && n < bound) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            rd(5'h04, v);
        end
    endtask

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values at each offset
        rd(5'h00, v); check("R1 control reset", v, 0);
        rd(5'h04, v); check("R1 status reset", v, 32'h08);
        rd(5'h10, v); check("R1 period reset", v, 32'hFFFE);
        rd(5'h0C, v); check("R12 sample read at reset", v, 0);
        check("R5 output after reset", pwm_out, 0);

        // R6: self-clearing soft reset flushes the queue
        wr(5'h0C, 32'd7); wr(5'h0C, 32'd9);
        rd(5'h04, v); check("R7 count after two writes", v[2:0], 2);
        wr(5'h10, 32'd33);
        wr(5'h00, 32'h8);
        rd(5'h00, v); check("R6 reset bit reads one", v[3], 1);
        repeat (RSTC) @(negedge clk);
        rd(5'h00, v); check("R6 reset bit self-clears", v[3], 0);
        rd(5'h04, v); check("R6 queue flushed", v, 32'h08);
        rd(5'h10, v); check("R6 period restored", v, 32'hFFFE);

        // R7 and R8: fill, overflow, error flag and clear
        for (int i = 0; i < 4; i++) wr(5'h0C, 32'(10 + i));
        rd(5'h04, v); check("R7 count full", v[3:0], 4);
        wr(5'h0C, 32'd99);
        rd(5'h04, v); check("R8 count kept at full", v[2:0], 4);
        check("R8 error flag set", v[6], 1);
        wr(5'h10, 32'd20);
        wr(5'h00, 32'h1_0001);
        @(negedge clk);
        rd(5'h0C, v); check("R12 first queued value active", v, 10);
        wr(5'h04, 32'h40);
        rd(5'h04, v); check("R11 error flag cleared", v[6], 0);

        // R12: sample read while disabled
        wr(5'h00, 32'h1_0000);
        rd(5'h0C, v); check("R12 sample reads zero when disabled", v, 0);

        // R2: first rollover latency and 0xFFFF equivalence
        first_rollover(3, 100, n);
        check("R2 rollover latency p=3", n, 6);
        rd(5'h04, v); check("R11 compare flag set", v[5], 1);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h30);
        rd(5'h04, v); check("R11 rov and cmp cleared", v[5:4], 0);
        first_rollover(32'hFFFF, 70000, n);
        check("R2 period 0xFFFF acts as 0xFFFE", n, 32'hFFFE + 3);

        // R13: gate field zero stops the counter
        soft_reset();
        wr(5'h10, 32'd1);
        wr(5'h00, 32'h1);
        repeat (30) @(negedge clk);
        rd(5'h04, v); check("R13 no rollover with gate off", v[4], 0);

        // R9: repeat setting decides when the next value is taken
        for (int c = 0; c < 4; c++) begin
            soft_reset();
            wr(5'h10, 32'd2);
            for (int i = 0; i < 3; i++) wr(5'h0C, 32'd1);
            wr(5'h00, 32'h1_0001 | (32'(c) << 1));
            n = 0;
            v = 32'd3;
            while (v[2:0] != 3'd1 && n < 200) begin
                @(posedge clk);
                n++;
                @(negedge clk);
                rd(5'h04, v);
            end
            check("R9 next value taken after 2^c periods", n, (1 << c) * 4 + 1);
        end

        // R3/R4/R10: sweep period, duty, divide ratio, polarity
        for (int dv = 1; dv <= 3; dv++)
            for (int p = 0; p <= 4; p++)
                for (int d = 0; d <= p + 3; d++)
                    for (int m = 0; m < 2; m++)
                        sweep_point(p, d, dv, m, 1'b1);
        // R4: output off modes; R5: disabled output low in both polarities
        sweep_point(3, 2, 1, 2, 1'b1);
        sweep_point(3, 2, 2, 3, 1'b1);
        sweep_point(3, 2, 1, 0, 1'b0);
        sweep_point(3, 2, 1, 1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule